// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable ratio of N·P + A. It does this with a dual-modulus prescaler and two down-counters. The prescaler divides by P or by P+1, where P is 64 or 32 depending on a range select. A swallow counter holds the prescaler at P+1 for the first A prescaler cycles of every output period. A main counter then ends the period after N prescaler cycles in total. The divided output is a one-cycle pulse. A phase/frequency detector uses it as its comparison input, and it can also be routed to a test pin so that the divider programming can be checked.

The swallow value A, the main value N and the range select arrive as parallel, already-latched values. The block captures them only at the reload point that ends each output period, so a change in the middle of a period never shortens or stretches that period. A configuration with A greater than N, or with N equal to zero, is reported as invalid on a separate output. In that case the output timing is unspecified.

Top module: `pswl_divider`

## Requirements
- R1: While `rst_n` is low, `cmp_pulse` and `mod_ctl` are both 0.
- R2: With `range_sel` = 0 (P = 64), consecutive `cmp_pulse` rises are N·64 + A input cycles apart.
- R3: With `range_sel` = 1 (P = 32), consecutive `cmp_pulse` rises are N·32 + A input cycles apart.
- R4: With A = 0, the period is exactly N·P cycles and `mod_ctl` stays 0 for the whole period.
- R5: With A = N, every prescaler cycle uses P+1, so the period is N·(P+1) cycles.
- R6: `cmp_pulse` is high for exactly one input cycle per output period.
- R7: In each period, `mod_ctl` is 1 for exactly A·(P+1) cycles, counted from the reload, and is 0 for the rest of the period. It changes only at a prescaler-cycle boundary.
- R8: New values of A, N or `range_sel` are captured only at the reload. A period that is already running keeps its old length, and the following period uses the new ratio.
- R9: `cfg_bad` is 1 exactly when A > N or N = 0. It follows the inputs combinationally.
- R10: After reset is released, the first `cmp_pulse` is seen after the (N·P + A + 1)-th rising edge. The first edge captures the configuration, and a full period follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| swallow_a | input | A_W (7) | Swallow value A: number of P+1 prescaler cycles per period |
| main_n | input | N_W (11) | Main value N: total prescaler cycles per period |
| range_sel | input | 1 | Prescaler range: 0 selects 64/65, 1 selects 32/33 |
| cmp_pulse | output | 1 | Divided output, one input cycle wide per period |
| mod_ctl | output | 1 | Modulus control: 1 while the prescaler divides by P+1 |
| cfg_bad | output | 1 | 1 when A > N or N = 0 |

## Verification
Every result of the divider is registered except `cfg_bad`. The bench therefore samples `cfg_bad` one time step after it drives the inputs. All other outputs are sampled at falling edges. The reload and the pulse register update on the same rising edge, so a period counted from one pulse sample to the next equals N·P + A exactly. Within that window, the `mod_ctl` samples are counted from the pulse sample onward, which gives A·(P+1). Configuration changes are applied at a falling edge. The first pulse seen afterwards still closes a period with the old ratio, so the new ratio is measured only over the period that follows it.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
   typedef enum logic {
      RANGE_WIDE   = 1'b0,
      RANGE_NARROW = 1'b1
   } range_e;
endpackage

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
   parameter int P_WIDE   = 64,
   parameter int P_NARROW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  pswl_pkg::range_e rng,
   input  logic            mod_hi,
   output logic            tick
);
   localparam int PC_W = $clog2(P_WIDE + 2);

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] base_idx;
   logic [PC_W-1:0] last_idx;

   generate
      if (P_NARROW < 2) begin : g_bad_narrow
         $error("P_NARROW must be at least 2");
      end
      if (P_NARROW >= P_WIDE) begin : g_bad_order
         $error("P_NARROW must be below P_WIDE");
      end
   endgenerate

   always_comb begin
      base_idx = (rng == pswl_pkg::RANGE_NARROW) ? PC_W'(P_NARROW - 1) : PC_W'(P_WIDE - 1);
      last_idx = base_idx + {{(PC_W-1){1'b0}}, mod_hi};
      tick     = !hold && (pc == last_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (hold || tick) begin
         pc <= '0;
      end else begin
         pc <= pc + 1'b1;
      end
   end

   // R7
   pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= PC_W'(P_WIDE));
endmodule

// File: rtl/pswl_swallow.sv
module pswl_swallow #(
   parameter int A_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [A_W-1:0] a_in,
   output logic           mod_hi
);
   logic [A_W-1:0] a_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_cnt <= '0;
      end else if (load) begin
         a_cnt <= a_in;
      end else if (step && (a_cnt != '0)) begin
         a_cnt <= a_cnt - 1'b1;
      end
   end

   assign mod_hi = (a_cnt != '0);

   // R7
   mod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(mod_hi));
endmodule

// File: rtl/pswl_main.sv
module pswl_main #(
   parameter int N_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [N_W-1:0] n_in,
   output logic           last
);
   logic [N_W-1:0] n_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_cnt <= '0;
      end else if (load) begin
         n_cnt <= n_in;
      end else if (step) begin
         n_cnt <= n_cnt - 1'b1;
      end
   end

   assign last = (n_cnt == N_W'(1));
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
   parameter int A_W      = 7,
   parameter int N_W      = 11,
   parameter int P_WIDE   = 64,
   parameter int P_NARROW = 32
) (
   input  logic           in_clk,
   input  logic           rst_n,
   input  logic [A_W-1:0] swallow_a,
   input  logic [N_W-1:0] main_n,
   input  logic           range_sel,
   output logic           cmp_pulse,
   output logic           mod_ctl,
   output logic           cfg_bad
);
   localparam int PER_W = N_W + $clog2(P_WIDE + 1) + 1;

   logic             pend;
   logic             tick;
   logic             last_n;
   logic             reload;
   logic             pulse_q;
   pswl_pkg::range_e rng_q;

   generate
      if (A_W < 1 || N_W < 2) begin : g_bad_width
         $error("counter widths too small");
      end
   endgenerate

   assign reload = pend || (tick && last_n);

   always_ff @(posedge in_clk) begin
      if (!rst_n) begin
         pend    <= 1'b1;
         pulse_q <= 1'b0;
         rng_q   <= pswl_pkg::RANGE_WIDE;
      end else begin
         pend    <= 1'b0;
         pulse_q <= tick && last_n;
         if (reload) begin
            rng_q <= pswl_pkg::range_e'(range_sel);
         end
      end
   end

   pswl_prescaler #(.P_WIDE(P_WIDE), .P_NARROW(P_NARROW)) u_pre (
      .clk    (in_clk),
      .rst_n  (rst_n),
      .hold   (pend),
      .rng    (rng_q),
      .mod_hi (mod_ctl),
      .tick   (tick)
   );

   pswl_swallow #(.A_W(A_W)) u_swl (
      .clk    (in_clk),
      .rst_n  (rst_n),
      .load   (reload),
      .step   (tick),
      .a_in   (swallow_a),
      .mod_hi (mod_ctl)
   );

   pswl_main #(.N_W(N_W)) u_main (
      .clk   (in_clk),
      .rst_n (rst_n),
      .load  (reload),
      .step  (tick),
      .n_in  (main_n),
      .last  (last_n)
   );

   assign cmp_pulse = pulse_q;
   assign cfg_bad   = (int'(swallow_a) > int'(main_n)) || (main_n == '0);

   // Checker state: the length of the running period against the ratio captured at reload
   logic [PER_W-1:0] per_cnt;
   logic [PER_W-1:0] exp_len;
   logic             exp_ok;

   always_ff @(posedge in_clk) begin
      if (!rst_n) begin
         per_cnt <= '0;
         exp_len <= '0;
         exp_ok  <= 1'b0;
      end else if (reload) begin
         per_cnt <= PER_W'(1);
         exp_len <= PER_W'(main_n) * PER_W'(range_sel ? P_NARROW : P_WIDE) + PER_W'(swallow_a);
         exp_ok  <= !cfg_bad;
      end else begin
         per_cnt <= per_cnt + 1'b1;
      end
   end

   // R2 R3
   period_len_chk: assert property (@(posedge in_clk) disable iff (!rst_n)
      (tick && last_n && exp_ok) |-> (per_cnt == exp_len));

   // R6
   single_pulse_chk: assert property (@(posedge in_clk) disable iff (!rst_n)
      cmp_pulse |=> !cmp_pulse);

   // R7
   mod_fall_chk: assert property (@(posedge in_clk) disable iff (!rst_n)
      $fell(mod_ctl) |-> $past(tick));
endmodule

// File: tb/sim_pswl_divider.sv
`timescale 1ns/1ps
module sim_pswl_divider;
   logic        in_clk = 1'b0;
   logic        rst_n  = 1'b0;
   logic [6:0]  swallow_a = '0;
   logic [10:0] main_n = 11'd1;
   logic        range_sel = 1'b0;
   logic        cmp_pulse, mod_ctl, cfg_bad;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 in_clk = ~in_clk;

   pswl_divider u0 (
      .in_clk    (in_clk),
      .rst_n     (rst_n),
      .swallow_a (swallow_a),
      .main_n    (main_n),
      .range_sel (range_sel),
      .cmp_pulse (cmp_pulse),
      .mod_ctl   (mod_ctl),
      .cfg_bad   (cfg_bad)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int n, input int a, input bit sel);
      main_n    = 11'(n);
      swallow_a = 7'(a);
      range_sel = sel;
   endtask

   task automatic wait_pulse();
      do @(negedge in_clk); while (!cmp_pulse);
   endtask

   // starts at a falling edge where cmp_pulse is high
   task automatic measure(output int len, output int hi, output int wide);
      len = 0; hi = 0; wide = 0;
      do begin
         if (mod_ctl) hi++;
         @(negedge in_clk);
         len++;
         if (len == 1 && cmp_pulse) wide = 1;
      end while (!cmp_pulse);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge in_clk);
      chk(cmp_pulse == 1'b0, "R1 pulse", int'(cmp_pulse), 0);
      chk(mod_ctl == 1'b0, "R1 modctl", int'(mod_ctl), 0);
   endtask

   task automatic t_first(input int n, input int a, input bit sel);
      int k;
      int p;
      p = sel ? 32 : 64;
      set_cfg(n, a, sel);
      t_reset();
      rst_n = 1'b1;
      k = 0;
      do begin @(negedge in_clk); k++; end while (!cmp_pulse && k < 5000);
      chk(k == n*p + a + 1, "R10 first pulse", k, n*p + a + 1);
   endtask

   task automatic t_period(input int n, input int a, input bit sel, input string req);
      int len, hi, wide, p;
      p = sel ? 32 : 64;
      set_cfg(n, a, sel);
      wait_pulse();
      measure(len, hi, wide);
      chk(len == n*p + a, req, len, n*p + a);
      chk(hi == a*(p+1), "R7 modctl high cycles", hi, a*(p+1));
      chk(wide == 0, "R6 pulse width", wide, 0);
   endtask

   task automatic t_midchange();
      int len, hi, wide, cnt;
      set_cfg(3, 2, 1'b0);
      wait_pulse();
      cnt = 0;
      repeat (5) begin @(negedge in_clk); cnt++; end
      set_cfg(7, 5, 1'b1);
      do begin @(negedge in_clk); cnt++; end while (!cmp_pulse);
      chk(cnt == 3*64 + 2, "R8 running period kept", cnt, 3*64 + 2);
      measure(len, hi, wide);
      chk(len == 7*32 + 5, "R8 next period new", len, 7*32 + 5);
   endtask

   task automatic t_flag();
      set_cfg(5, 6, 1'b0); #1;
      chk(cfg_bad == 1'b1, "R9 A>N", int'(cfg_bad), 1);
      set_cfg(0, 0, 1'b0); #1;
      chk(cfg_bad == 1'b1, "R9 N=0", int'(cfg_bad), 1);
      set_cfg(6, 6, 1'b1); #1;
      chk(cfg_bad == 1'b0, "R9 A=N", int'(cfg_bad), 0);
      set_cfg(2047, 127, 1'b0); #1;
      chk(cfg_bad == 1'b0, "R9 max", int'(cfg_bad), 0);
   endtask

   initial begin
      repeat (200000) @(posedge in_clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_first(5, 3, 1'b0);
      t_period(5, 3, 1'b0, "R2 ratio P=64");
      t_period(2, 1, 1'b0, "R2 ratio P=64 short");
      t_period(9, 7, 1'b1, "R3 ratio P=32");
      t_period(4, 0, 1'b1, "R4 A=0");
      t_period(6, 6, 1'b0, "R5 A=N");
      t_period(1, 1, 1'b1, "R5 A=N=1");
      t_midchange();
      t_flag();
      t_first(2, 2, 1'b1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule